// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Counter

This block is a tick-driven counter for timing and waveform generation. A prescaler divides the clock, and on each prescaled tick the count moves one step between zero and a programmable reload value. The direction setting picks one of three patterns:

- rising with a wrap to zero;
- falling from the reload value with a wrap back to it;
- a triangle that climbs to the reload value and returns to zero.

In periodic mode the pattern repeats without end. In one-shot mode it runs one pass, stops at its terminal value, and waits for a restart strobe.

On every tick the block reports what the count reached, as one-cycle pulses aligned with the count update. The reported values are zero, the reload value, and two compare values. Each compare pulse is split by the direction of the step that reached it. Three summary flags give a match on each compare value in either direction and the end of a count period. The surrounding register file drives the configuration inputs directly.

Top module: `tick_timer`

## Requirements
- R1: While `run_en` is high and the counter has not finished, the count takes exactly one step every `prescale`+1 clock cycles, counted from reset or from the last restart.
- R2: With `dir_mode` = 2'b00 (2'b11 behaves the same), the count rises by one per tick up to `reload_val`. In periodic mode the following tick returns it to 0.
- R3: With `dir_mode` = 2'b01, the count falls by one per tick from `reload_val` to 0. In periodic mode the following tick returns it to `reload_val`.
- R4: With `dir_mode` = 2'b10, the count rises from 0 to `reload_val` and then falls back to 0, repeating. `counting_down` is 1 after the tick that reached `reload_val` and stays 1 until the tick that reaches 0. It is always 0 for 2'b00 and always 1 for 2'b01.
- R5: With `one_shot` high, the count stops at the terminal value: `reload_val` for 2'b00, and 0 for 2'b01 and 2'b10. It then stays there with no further events.
- R6: A `restart` pulse reloads the start value on the next edge and clears the prescaler. The start value is 0 for 2'b00 and 2'b10, and `reload_val` for 2'b01. Counting then resumes as from reset.
- R7: While `run_en` is low, the count, the direction and the prescaler phase hold, and no event is issued.
- R8: `ev_zero` and `ev_reload` are high for one cycle, in the same cycle that the count first shows 0 or `reload_val` after a tick.
- R9: `ev_x_up` and `ev_y_up` pulse when a rising step reaches `cmp_x` or `cmp_y`. `ev_x_down` and `ev_y_down` pulse when a falling step reaches them. Wraps count as a step in the mode's direction: rising for 2'b00, falling for 2'b01.
- R10: `match_x` and `match_y` pulse whenever the matching compare event pulses in either direction. `timeout` pulses when a tick reaches the terminal value: `reload_val` for 2'b00, and 0 for 2'b01 and 2'b10.
- R11: Synchronous reset (`rst_n` low) sets the count to 0, or to `reload_val` in mode 2'b01. It also clears the prescaler, the finished state and all events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Counting enable |
| restart | input | 1 | One-cycle restart strobe |
| dir_mode | input | 2 | 00 up, 01 down, 10 up/down, 11 up |
| one_shot | input | 1 | 1 = single pass, 0 = periodic |
| prescale | input | PRE_W | Tick divider minus one |
| reload_val | input | CNT_W | Top of count range |
| cmp_x | input | CNT_W | First compare value |
| cmp_y | input | CNT_W | Second compare value |
| count | output | CNT_W | Current count |
| counting_down | output | 1 | Direction of the counter |
| ev_zero | output | 1 | Count reached 0 |
| ev_reload | output | 1 | Count reached reload_val |
| ev_x_up | output | 1 | cmp_x reached on a rising step |
| ev_y_up | output | 1 | cmp_y reached on a rising step |
| ev_x_down | output | 1 | cmp_x reached on a falling step |
| ev_y_down | output | 1 | cmp_y reached on a falling step |
| match_x | output | 1 | cmp_x reached in either direction |
| match_y | output | 1 | cmp_y reached in either direction |
| timeout | output | 1 | End of a count period |

## Verification

The sweep runs every pairing of the three direction modes with periodic and one-shot operation. Each pairing is tried with prescale values of 0, 1 and 2 and reload values of 1, 3 and 4. These settings separate an off-by-one in the divider, a wrap to the wrong end, a triangle that repeats its peak or trough, and a one-shot that overruns its terminal value. With compare values placed at 1 and `reload_val`-1, the same value is reached once while rising and once while falling, which exposes wrong direction qualification. Directed runs drop the enable in the middle of a prescaler phase, and restart a finished one-shot, to show that the phase is kept and then cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        DIR_UP   = 2'b00,
        DIR_DOWN = 2'b01,
        DIR_BOTH = 2'b10,
        DIR_ALT  = 2'b11
    } dir_e;

    typedef struct packed {
        logic zero;
        logic top;
        logic x_up;
        logic y_up;
        logic x_dn;
        logic y_dn;
        logic term;
    } evt_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q >= limit);
        div_d = div_q;
        if (clear) begin
            div_d = '0;
            tick  = 1'b0;
        end else if (run) begin
            div_d = tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] top,
    input  logic         falling,
    input  dir_e         dir,
    output logic [W-1:0] nxt,
    output logic         step_down,
    output logic         falling_nxt,
    output logic         at_term
);
    logic go_down;

    always_comb begin
        go_down = 1'b0;
        case (dir)
            DIR_DOWN: begin
                step_down   = 1'b1;
                nxt         = (cur == '0) ? top : cur - 1'b1;
                falling_nxt = 1'b1;
                at_term     = (nxt == '0);
            end
            DIR_BOTH: begin
                go_down     = (cur != '0) && (falling || cur >= top);
                step_down   = go_down;
                if (top == '0)   nxt = '0;
                else if (go_down) nxt = cur - 1'b1;
                else              nxt = cur + 1'b1;
                if (nxt == top && top != '0) falling_nxt = 1'b1;
                else if (nxt == '0)          falling_nxt = 1'b0;
                else                         falling_nxt = go_down;
                at_term     = (nxt == '0);
            end
            default: begin
                step_down   = 1'b0;
                nxt         = (cur >= top) ? '0 : cur + 1'b1;
                falling_nxt = 1'b0;
                at_term     = (nxt == top);
            end
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart,
    input  logic [1:0]       dir_mode,
    input  logic             one_shot,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_x,
    input  logic [CNT_W-1:0] cmp_y,
    output logic [CNT_W-1:0] count,
    output logic             counting_down,
    output logic             ev_zero,
    output logic             ev_reload,
    output logic             ev_x_up,
    output logic             ev_y_up,
    output logic             ev_x_down,
    output logic             ev_y_down,
    output logic             match_x,
    output logic             match_y,
    output logic             timeout
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             falling;
        logic             done;
        evt_t             ev;
    } state_t;

    state_t           st_d, st_q;
    dir_e             dir;
    logic             tick;
    logic [CNT_W-1:0] nxt;
    logic             step_down, falling_nxt, at_term;
    logic [CNT_W-1:0] start_val;

    assign dir       = dir_e'(dir_mode);
    assign start_val = (dir == DIR_DOWN) ? reload_val : '0;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en && !st_q.done),
        .clear (restart),
        .limit (prescale),
        .tick  (tick)
    );

    tmr_step #(.W(CNT_W)) u_step (
        .cur         (st_q.cnt),
        .top         (reload_val),
        .falling     (st_q.falling),
        .dir         (dir),
        .nxt         (nxt),
        .step_down   (step_down),
        .falling_nxt (falling_nxt),
        .at_term     (at_term)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ev = '0;
        if (restart) begin
            st_d.cnt     = start_val;
            st_d.falling = (dir == DIR_DOWN);
            st_d.done    = 1'b0;
        end else if (tick) begin
            st_d.cnt     = nxt;
            st_d.falling = falling_nxt;
            st_d.ev.zero = (nxt == '0);
            st_d.ev.top  = (nxt == reload_val);
            st_d.ev.x_up = (nxt == cmp_x) && !step_down;
            st_d.ev.y_up = (nxt == cmp_y) && !step_down;
            st_d.ev.x_dn = (nxt == cmp_x) && step_down;
            st_d.ev.y_dn = (nxt == cmp_y) && step_down;
            st_d.ev.term = at_term;
            st_d.done    = one_shot && at_term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= start_val;
            st_q.falling <= (dir == DIR_DOWN);
            st_q.done    <= 1'b0;
            st_q.ev      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count         = st_q.cnt;
    assign counting_down = st_q.falling;
    assign ev_zero       = st_q.ev.zero;
    assign ev_reload     = st_q.ev.top;
    assign ev_x_up       = st_q.ev.x_up;
    assign ev_y_up       = st_q.ev.y_up;
    assign ev_x_down     = st_q.ev.x_dn;
    assign ev_y_down     = st_q.ev.y_dn;
    assign match_x       = st_q.ev.x_up | st_q.ev.x_dn;
    assign match_y       = st_q.ev.y_up | st_q.ev.y_dn;
    assign timeout       = st_q.ev.term;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         restart,
    input logic [1:0]   dir_mode,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] cmp_x,
    input logic [W-1:0] cmp_y,
    input logic [W-1:0] count,
    input logic         done,
    input logic         tick,
    input logic         ev_zero,
    input logic         ev_x_up,
    input logic         ev_y_down,
    input logic         timeout
);
    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !restart) |=> $stable(count));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> $stable(count));

    assert_zero_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_zero |-> (count == '0));

    assert_cmpx_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_x_up |-> (count == $past(cmp_x)));

    assert_cmpy_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_y_down |-> (count == $past(cmp_y)));

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && dir_mode == 2'b00 && count < reload_val)
        |=> (count == W'($past(count) + 1'b1)));

    assert_up_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && dir_mode == 2'b00) |-> (count == reload_val));
endmodule

bind tick_timer tick_timer_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .restart    (restart),
    .dir_mode   (dir_mode),
    .reload_val (reload_val),
    .cmp_x      (cmp_x),
    .cmp_y      (cmp_y),
    .count      (count),
    .done       (st_q.done),
    .tick       (tick),
    .ev_zero    (ev_zero),
    .ev_x_up    (ev_x_up),
    .ev_y_down  (ev_y_down),
    .timeout    (timeout)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    localparam int CW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          restart = 1'b0;
    logic [1:0]    dir_mode = 2'b00;
    logic          one_shot = 1'b0;
    logic [PW-1:0] prescale = '0;
    logic [CW-1:0] reload_val = 32'd1;
    logic [CW-1:0] cmp_x = '0;
    logic [CW-1:0] cmp_y = '0;
    logic [CW-1:0] count;
    logic counting_down, ev_zero, ev_reload, ev_x_up, ev_y_up;
    logic ev_x_down, ev_y_down, match_x, match_y, timeout;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tick_timer #(.CNT_W(CW), .PRE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(restart),
        .dir_mode(dir_mode), .one_shot(one_shot), .prescale(prescale),
        .reload_val(reload_val), .cmp_x(cmp_x), .cmp_y(cmp_y),
        .count(count), .counting_down(counting_down), .ev_zero(ev_zero),
        .ev_reload(ev_reload), .ev_x_up(ev_x_up), .ev_y_up(ev_y_up),
        .ev_x_down(ev_x_down), .ev_y_down(ev_y_down), .match_x(match_x),
        .match_y(match_y), .timeout(timeout)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_cnt(input int m, input int l, input int t);
        if (m == 1) return l - (t % (l + 1));
        if (m == 2) begin
            int ph = t % (2 * l);
            return (ph <= l) ? ph : 2 * l - ph;
        end
        return t % (l + 1);
    endfunction

    function automatic int term_ticks(input int m, input int l);
        return (m == 2) ? 2 * l : l;
    endfunction

    // Compare outputs after n enabled edges since reset or restart
    task automatic check_at(input int m, input bit os, input int p, input int l, input int n);
        int  t    = n / (p + 1);
        int  lim  = term_ticks(m, l);
        bit  tk   = (n > 0) && (n % (p + 1) == 0) && (!os || t <= lim);
        int  te   = (os && t > lim) ? lim : t;
        longint c = exp_cnt(m, l, te);
        bit  dn_step = (m == 1) || (m == 2 && ((te - 1) % (2 * l)) >= l);
        bit  dn_now  = (m == 1) || (m == 2 && (te % (2 * l)) >= l);
        longint term = (m == 0) ? l : 0;
        logic [9:0] e_exp, e_act;
        e_exp = {tk && c == 0, tk && c == l,
                 tk && c == cmp_x && !dn_step, tk && c == cmp_y && !dn_step,
                 tk && c == cmp_x && dn_step,  tk && c == cmp_y && dn_step,
                 tk && c == cmp_x, tk && c == cmp_y, tk && c == term, 1'b0};
        e_act = {ev_zero, ev_reload, ev_x_up, ev_y_up, ev_x_down, ev_y_down,
                 match_x, match_y, timeout, 1'b0};
        chk("R1 R2 R3 R4 R5 count", count, c);
        chk("R4 counting_down", counting_down, dn_now);
        chk("R8 R9 R10 events", e_act, e_exp);
    endtask

    task automatic start_run(input int m, input bit os, input int p, input int l);
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0;
        dir_mode = m[1:0]; one_shot = os; prescale = p[PW-1:0];
        reload_val = l; cmp_x = 1; cmp_y = l - 1;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset count", count, (m == 1) ? l : 0);
        chk("R11 reset events", {ev_zero, ev_reload, timeout, match_x}, 0);
        run_en = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lvals[3] = '{1, 3, 4};
        // Main sweep
        for (int m = 0; m < 3; m++)
            for (int os = 0; os < 2; os++)
                for (int p = 0; p < 3; p++)
                    for (int li = 0; li < 3; li++) begin
                        int l = lvals[li];
                        int nmax = (2 * l + 2) * (p + 1) + 2;
                        start_run(m, os[0], p, l);
                        for (int n = 1; n <= nmax; n++) begin
                            @(negedge clk);
                            check_at(m, os[0], p, l, n);
                        end
                    end

        // R7: enable low freezes count and prescaler phase
        start_run(0, 1'b0, 1, 5);
        for (int n = 1; n <= 5; n++) begin @(negedge clk); check_at(0, 1'b0, 1, 5, n); end
        run_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R7 frozen count", count, 2);
            chk("R7 no events", {ev_zero, ev_reload, ev_x_up, match_y, timeout}, 0);
        end
        run_en = 1'b1;
        for (int n = 6; n <= 14; n++) begin @(negedge clk); check_at(0, 1'b0, 1, 5, n); end

        // R6: restart a finished one-shot, with prescaler cleared
        for (int m = 0; m < 3; m++) begin
            start_run(m, 1'b1, 2, 3);
            for (int n = 1; n <= 25; n++) begin @(negedge clk); check_at(m, 1'b1, 2, 3, n); end
            restart = 1'b1;
            @(negedge clk);
            restart = 1'b0;
            chk("R6 restart count", count, (m == 1) ? 3 : 0);
            chk("R6 restart events", {ev_zero, ev_reload, timeout}, 0);
            for (int n = 1; n <= 25; n++) begin @(negedge clk); check_at(m, 1'b1, 2, 3, n); end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule